// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache Controller

This block sits between a processor's word-oriented load/store port and a slow main memory. Storage is organised as four-way sets. Each way holds a valid flag, a dirty flag, an address tag and a block of four 32-bit words. Reads and writes that hit complete in the cycle they are presented. Writes that hit touch only the cache copy and mark the line dirty.

A miss of either kind allocates a line. A victim way is chosen, its block is copied back to memory if it is dirty, and the requested block is fetched into that way one word per memory beat. A store that missed is then merged into the freshly loaded block. Victims come from a per-set binary-tree pseudo-LRU selector unless the set still has an empty way.

The processor keeps its request (valid, write flag, address, write data) stable until ready is seen high. The memory side holds a request with address, direction and write data until it sees an acknowledge, one word per acknowledged beat.

Top module: `wbc_cache_top`

## Requirements
- R1: Address bits [1:0] are ignored, bits [3:2] select the word within the block, the next SET_W bits select the set, and the remaining TAG_W upper bits form the tag; two addresses differing only in bits [1:0] return the same word.
- R2: A way hits only when it is valid and its stored tag equals the address tag; after reset every access misses, and at most one way of a set hits.
- R3: A read hit raises cpu_ready and cpu_hit in the same cycle as the request and returns the addressed word on cpu_rdata.
- R4: A write hit changes only the addressed word, marks the line dirty and causes no memory request.
- R5: On a miss the block is fetched with exactly four read beats at word addresses block*4+0, +1, +2, +3 in that order, into the victim way.
- R6: If the victim is valid and dirty, its four words are written to memory at the victim's own tag and set, word 0 first, before any refill beat; afterwards memory holds the latest data of that block.
- R7: A clean or empty victim causes no write beat.
- R8: On a write miss the store word is merged after the refill and the line becomes dirty, so a later eviction writes it back.
- R9: The victim is the lowest-numbered invalid way of the set; if all four are valid it comes from a three-bit tree per set, where the root bit names the pair to replace (0: ways 0/1, 1: ways 2/3) and each pair bit names the way within its pair (0: lower, 1: upper); every hit or fill points all bits on the path away from the accessed way.
- R10: cpu_ready is low from the cycle a miss is seen until the completion cycle; in that cycle cpu_ready is high, cpu_hit is low and cpu_rdata carries the refilled word.
- R11: A synchronous reset clears every valid bit, dirty bit and replacement tree (victim order 0, then 2 within the right pair); with no request pending cpu_ready is high and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+SET_W+4 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion was a hit |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat (copy-back), 0 = read beat (refill) |
| mem_addr | output | TAG_W+SET_W+4 | Byte address of the beat's word |
| mem_wdata | output | 32 | Copy-back data |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 32 | Refill data |

## Verification
A reduced configuration (four sets, eight tags per set) is driven first with ascending read and write sweeps across the whole address space, which separate same-block hits from first-touch misses and leave dirty lines to be evicted. A long pseudo-random mix of loads and stores with arbitrary byte-offset bits then keeps sets full, so victim order tells the tree replacement apart from true LRU or round-robin, and the copy-back beat count and addresses tell dirty evictions from clean ones. Memory acknowledges are stalled every third cycle to show that beats advance only on acknowledge, and a reset in the middle of the run shows that dirty contents are dropped and every line misses again.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  localparam int WAYS   = 4;
  localparam int WPB    = 4;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } miss_state_t;

  // Tree: bit0 = pair to evict (0 low pair), bit1 = way in low pair, bit2 = way in high pair.
  function automatic logic [1:0] tree_pick(input logic [2:0] t);
    logic [1:0] w;
    if (!t[0]) w = {1'b0, t[1]};
    else       w = {1'b1, t[2]};
    return w;
  endfunction

  function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] lowest_free(input logic [3:0] vld);
    logic [1:0] w;
    w = 2'd0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld[i]) w = 2'(i);
    end
    return w;
  endfunction

  function automatic logic [1:0] way_encode(input logic [3:0] hv);
    logic [1:0] w;
    w = 2'd0;
    for (int i = 0; i < WAYS; i++) begin
      if (hv[i]) w = 2'(i);
    end
    return w;
  endfunction

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int TAG_W = 20,
  parameter int SET_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SET_W-1:0]      set_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [3:0]            hit_o,
  output logic [3:0]            vld_o,
  output logic [3:0]            dirty_o,
  output logic [3:0][TAG_W-1:0] tags_o,
  input  logic                  fill_en_i,
  input  logic [1:0]            fill_way_i,
  input  logic                  fill_dirty_i,
  input  logic                  dset_en_i,
  input  logic [1:0]            dset_way_i
);
  localparam int SETS = 1 << SET_W;

  logic [3:0]            vld_q   [SETS];
  logic [3:0]            dirty_q [SETS];
  logic [3:0][TAG_W-1:0] tag_q   [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_en_i) begin
        vld_q[set_i][fill_way_i]   <= 1'b1;
        dirty_q[set_i][fill_way_i] <= fill_dirty_i;
      end
      if (dset_en_i) dirty_q[set_i][dset_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) tag_q[set_i][fill_way_i] <= tag_i;
  end

  assign vld_o   = vld_q[set_i];
  assign dirty_o = dirty_q[set_i];
  assign tags_o  = tag_q[set_i];

  for (genvar w = 0; w < 4; w++) begin : g_cmp
    assign hit_o[w] = vld_o[w] && (tags_o[w] == tag_i);
  end

  a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_o));
  a_r4_dirty_on_valid: assert property (@(posedge clk) disable iff (rst)
    dset_en_i |-> vld_o[dset_way_i]);
  a_r11_cleared: assert property (@(posedge clk)
    $past(rst) |-> (vld_o == 4'b0) && (dirty_o == 4'b0));
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic [SET_W-1:0] set_i,
  input  logic [1:0]       rd_way_i,
  input  logic [1:0]       rd_word_i,
  output logic [31:0]      rd_data_o,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_way_i,
  input  logic [1:0]       wr_word_i,
  input  logic [31:0]      wr_data_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int DEPTH = SETS * 16;
  localparam int IDX_W = SET_W + 4;

  logic [31:0] word_q [DEPTH];

  function automatic logic [IDX_W-1:0] slot(input logic [SET_W-1:0] s,
                                           input logic [1:0] w, input logic [1:0] k);
    return {s, w, k};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en_i) word_q[slot(set_i, wr_way_i, wr_word_i)] <= wr_data_i;
  end

  assign rd_data_o = word_q[slot(set_i, rd_way_i, rd_word_i)];
endmodule

// File: rtl/wbc_plru.sv
module wbc_plru
  import wbc_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_en_i,
  input  logic [1:0]       touch_way_i,
  output logic [1:0]       pick_o
);
  localparam int SETS = 1 << SET_W;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en_i) begin
      tree_q[set_i] <= tree_touch(tree_q[set_i], touch_way_i);
    end
  end

  assign pick_o = tree_pick(tree_q[set_i]);

  a_r9_not_just_used: assert property (@(posedge clk) disable iff (rst)
    touch_en_i |=> ($past(set_i) != set_i) || (pick_o != $past(touch_way_i)));
endmodule

// File: rtl/wbc_cache_top.sv
module wbc_cache_top
  import wbc_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int SET_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_valid,
  input  logic                     cpu_we,
  input  logic [TAG_W+SET_W+3:0]   cpu_addr,
  input  logic [31:0]              cpu_wdata,
  output logic                     cpu_ready,
  output logic                     cpu_hit,
  output logic [31:0]              cpu_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [TAG_W+SET_W+3:0]   mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_ack,
  input  logic [31:0]              mem_rdata
);
  localparam int ADDR_W  = TAG_W + SET_W + 4;
  localparam int SET_LSB = 4;
  localparam int TAG_LSB = SET_W + 4;

  miss_state_t state_q;
  logic [1:0]  beat_q;
  logic [1:0]  vic_q;

  logic [SET_W-1:0] a_set;
  logic [TAG_W-1:0] a_tag;
  logic [1:0]       a_word;
  assign a_set  = cpu_addr[TAG_LSB-1:SET_LSB];
  assign a_tag  = cpu_addr[ADDR_W-1:TAG_LSB];
  assign a_word = cpu_addr[3:2];

  logic [3:0]            hit_vec, vld_vec, dirty_vec;
  logic [3:0][TAG_W-1:0] tag_vec;
  logic [1:0]            tree_way, vic_pick, hit_way, rd_way, rd_word;
  logic [31:0]           rd_data;

  // Named events
  logic in_idle, hit_any, lookup_hit_ev, miss_ev, wr_hit_ev, wb_beat_ev, fill_beat_ev, done_ev;
  logic victim_dirty, data_we;
  logic [1:0]  data_wway, data_wword;
  logic [31:0] data_wdata;

  assign in_idle       = (state_q == ST_IDLE);
  assign hit_any       = |hit_vec;
  assign hit_way       = way_encode(hit_vec);
  assign lookup_hit_ev = in_idle && cpu_valid && hit_any;
  assign miss_ev       = in_idle && cpu_valid && !hit_any;
  assign wr_hit_ev     = lookup_hit_ev && cpu_we;
  assign wb_beat_ev    = (state_q == ST_WBACK) && mem_ack;
  assign fill_beat_ev  = (state_q == ST_FILL) && mem_ack;
  assign done_ev       = (state_q == ST_DONE);
  assign vic_pick      = (&vld_vec) ? tree_way : lowest_free(vld_vec);
  assign victim_dirty  = vld_vec[vic_pick] && dirty_vec[vic_pick];

  wbc_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
    .clk(clk), .rst(rst), .set_i(a_set), .tag_i(a_tag),
    .hit_o(hit_vec), .vld_o(vld_vec), .dirty_o(dirty_vec), .tags_o(tag_vec),
    .fill_en_i(done_ev), .fill_way_i(vic_q), .fill_dirty_i(cpu_we),
    .dset_en_i(wr_hit_ev), .dset_way_i(hit_way)
  );

  wbc_plru #(.SET_W(SET_W)) u_plru (
    .clk(clk), .rst(rst), .set_i(a_set),
    .touch_en_i(lookup_hit_ev || done_ev),
    .touch_way_i(done_ev ? vic_q : hit_way),
    .pick_o(tree_way)
  );

  always_comb begin
    rd_way  = hit_way;
    rd_word = a_word;
    if (state_q == ST_WBACK) begin
      rd_way  = vic_q;
      rd_word = beat_q;
    end else if (done_ev) begin
      rd_way = vic_q;
    end
  end

  always_comb begin
    data_we    = 1'b0;
    data_wway  = vic_q;
    data_wword = a_word;
    data_wdata = cpu_wdata;
    if (wr_hit_ev) begin
      data_we   = 1'b1;
      data_wway = hit_way;
    end else if (fill_beat_ev) begin
      data_we    = 1'b1;
      data_wword = beat_q;
      data_wdata = mem_rdata;
    end else if (done_ev && cpu_we) begin
      data_we = 1'b1;
    end
  end

  wbc_data_store #(.SET_W(SET_W)) u_data (
    .clk(clk), .set_i(a_set),
    .rd_way_i(rd_way), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .wr_en_i(data_we), .wr_way_i(data_wway), .wr_word_i(data_wword), .wr_data_i(data_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= 2'd0;
      vic_q   <= 2'd0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_ev) begin
          vic_q   <= vic_pick;
          beat_q  <= 2'd0;
          state_q <= victim_dirty ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_ack) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = {(mem_we ? tag_vec[vic_q] : a_tag), a_set, beat_q, 2'b00};
  assign mem_wdata = rd_data;

  assign cpu_ready = (in_idle && !miss_ev) || done_ev;
  assign cpu_hit   = lookup_hit_ev;
  assign cpu_rdata = rd_data;

  a_r10_stall_during_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);
  a_r10_miss_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    miss_ev |-> !cpu_ready);
  a_r6_wback_then_fill: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && $past(state_q) == ST_WBACK) |-> $past(mem_ack && beat_q == 2'd3));
  a_r5_done_after_four: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> ($past(state_q) == ST_FILL) && $past(beat_q == 2'd3 && mem_ack));
  a_r4_hit_no_traffic: assert property (@(posedge clk) disable iff (rst)
    lookup_hit_ev |=> !mem_req);
  a_r7_clean_skips_wback: assert property (@(posedge clk) disable iff (rst)
    (miss_ev && !victim_dirty) |=> (state_q == ST_FILL));
endmodule

// File: tb/tb_wbc_cache_top.sv
module tb_wbc_cache_top;
  localparam int TAG_W  = 3;
  localparam int SET_W  = 2;
  localparam int ADDR_W = TAG_W + SET_W + 4;
  localparam int NSET   = 1 << SET_W;
  localparam int NWORDS = 1 << (ADDR_W - 2);
  localparam int LIMIT  = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  always #5 clk = ~clk;

  wbc_cache_top #(.TAG_W(TAG_W), .SET_W(SET_W)) dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] gmem [int];   // architectural view
  logic [31:0] bmem [int];   // main memory contents

  // cache model: most-recently-used formulation of the tree
  logic mv [NSET][4];
  logic md [NSET][4];
  int   mt [NSET][4];
  logic mru_left [NSET];
  logic mru_lo [NSET];
  logic mru_hi [NSET];

  int wb_beats, rf_beats, wb_bad, rf_bad, exp_wb_blk, exp_rf_blk;

  function automatic logic [31:0] seed_val(input int wa);
    return (wa * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction
  function automatic logic [31:0] gval(input int wa);
    return gmem.exists(wa) ? gmem[wa] : seed_val(wa);
  endfunction
  function automatic logic [31:0] bval(input int wa);
    return bmem.exists(wa) ? bmem[wa] : seed_val(wa);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NSET; s++) begin
      for (int w = 0; w < 4; w++) begin mv[s][w] = 1'b0; md[s][w] = 1'b0; mt[s][w] = 0; end
      mru_left[s] = 1'b0; mru_lo[s] = 1'b1; mru_hi[s] = 1'b1;
    end
  endtask

  function automatic int model_victim(input int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    if (mru_left[s]) return mru_hi[s] ? 2 : 3;
    return mru_lo[s] ? 0 : 1;
  endfunction

  task automatic model_touch(input int s, input int w);
    mru_left[s] = (w < 2);
    if (w < 2) mru_lo[s] = w[0];
    else       mru_hi[s] = w[0];
  endtask

  always @(posedge clk) cyc++;

  // memory responder: acknowledges two cycles out of three
  always @(negedge clk) begin
    if (mem_req && (cyc % 3 != 2)) begin
      int wa;
      wa = int'(mem_addr >> 2);
      mem_ack = 1'b1;
      if (mem_we) begin
        if (wa != exp_wb_blk * 4 + wb_beats || rf_beats != 0) wb_bad++;
        bmem[wa] = mem_wdata;
        wb_beats++;
      end else begin
        mem_rdata = bval(wa);
        if (wa != exp_rf_blk * 4 + rf_beats) rf_bad++;
        rf_beats++;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      total++; bad++;
      $display("FAIL R10 watchdog: cycles=%0d expected<%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // called at a negative edge; returns at a negative edge with cpu_valid low
  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] wd);
    int wa, s, t, hw, vw, n;
    logic vdirty;
    wa = int'(a >> 2);
    s  = (wa >> 2) % NSET;
    t  = wa >> (2 + SET_W);
    hw = -1;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
    wb_beats = 0; rf_beats = 0; wb_bad = 0; rf_bad = 0;
    exp_rf_blk = wa >> 2;
    vw = model_victim(s);
    vdirty = (hw < 0) && mv[s][vw] && md[s][vw];
    exp_wb_blk = mt[s][vw] * NSET + s;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    if (hw >= 0) begin
      chk("R3 ready on hit", 32'(cpu_ready), 32'd1);
      chk("R2 hit flag", 32'(cpu_hit), 32'd1);
      if (!we) chk("R3 read hit data", cpu_rdata, gval(wa));
      @(negedge clk);
      #1;
      chk("R4 no memory request after hit", 32'(mem_req), 32'd0);
      if (we) begin gmem[wa] = wd; md[s][hw] = 1'b1; end
      model_touch(s, hw);
    end else begin
      chk("R10 ready low on miss", 32'(cpu_ready), 32'd0);
      n = 0;
      while (!cpu_ready && n < 200) begin
        @(negedge clk);
        #1;
        n++;
      end
      chk("R10 completion hit low", 32'(cpu_hit), 32'd0);
      chk("R10 refilled word", cpu_rdata, gval(wa));
      chk("R5 refill beats", 32'(rf_beats), 32'd4);
      chk("R5 refill order", 32'(rf_bad), 32'd0);
      if (vdirty) begin
        chk("R6 writeback beats", 32'(wb_beats), 32'd4);
        chk("R6 writeback addresses", 32'(wb_bad), 32'd0);
        for (int k = 0; k < 4; k++)
          chk("R6 written-back data", bval(exp_wb_blk * 4 + k), gval(exp_wb_blk * 4 + k));
      end else begin
        chk("R7 no writeback for clean victim", 32'(wb_beats), 32'd0);
      end
      @(negedge clk);
      if (we) gmem[wa] = wd;
      mv[s][vw] = 1'b1; mt[s][vw] = t; md[s][vw] = we;
      model_touch(s, vw);
    end
    cpu_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    gmem = bmem;
    #1;
    chk("R11 ready idle after reset", 32'(cpu_ready), 32'd1);
    chk("R11 no memory request after reset", 32'(mem_req), 32'd0);
  endtask

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    @(negedge clk);
    do_reset();
    // R2: every word read once, ascending
    for (int i = 0; i < NWORDS; i++) access(1'b0, ADDR_W'(i << 2), 32'd0);
    // R4/R8: store to every word
    for (int i = 0; i < NWORDS; i++) access(1'b1, ADDR_W'(i << 2), 32'hA500_0000 + 32'(i));
    // R6: read everything back (dirty evictions)
    for (int i = NWORDS - 1; i >= 0; i--) access(1'b0, ADDR_W'(i << 2), 32'd0);
    // R1: byte-offset bits ignored
    access(1'b1, ADDR_W'(9'h035), 32'hDEAD_BEEF);
    access(1'b0, ADDR_W'(9'h036), 32'd0);
    access(1'b0, ADDR_W'(9'h037), 32'd0);
    chk("R1 byte offset ignored", gval(9'h035 >> 2), 32'hDEAD_BEEF);
    // R9: random mix keeps sets full
    for (int i = 0; i < 3000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      access(lf[31], lf[ADDR_W-1:0], lf ^ 32'h5555_AAAA);
    end
    // R11: reset drops dirty lines; everything misses again
    do_reset();
    for (int i = 0; i < NWORDS; i += 4) access(1'b0, ADDR_W'(i << 2), 32'd0);
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      access(lf[30], lf[ADDR_W-1:0], ~lf);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule